// File: doc/BRIEF.md
# Rotate-then-insert bit-field unit

This unit rotates a 64-bit source operand to the left and then merges a contiguous run of the rotated bits into a 64-bit destination operand. The run is given by a start index and an end index. Both indices count from the most significant bit of the active region. When start is greater than end, the run wraps past the last bit of the region and continues from its first bit.

A 2-bit variant code selects the active region: the whole word, the upper 32 bits, or the lower 32 bits. The half variants never touch the other half of the destination. The top bit of the end immediate is a zero option: it clears the destination bits in the active region that the run does not cover.

The unit has one register stage. An operation presented with `in_valid` shows up on `out_result` and `out_valid` one clock later. An execution pipeline uses it as a single-cycle functional unit.

Top module: `rib_unit`

## Requirements
- R1: The source is rotated left by `in_rot[5:0]` over all 64 bits before bits are selected; bits 7:6 of `in_rot` have no effect.
- R2: For the full variant (code 0), start and end are taken modulo 64, index 0 is result bit 63, and the result takes the rotated source on indices start through end inclusive when start <= end.
- R3: When the reduced start exceeds the reduced end, the inserted run covers start through the last index of the region and index 0 through end.
- R4: For the high variant (code 1), start and end are taken modulo 32, index 0 is result bit 63, insertion happens only in bits 63:32, and result bits 31:0 equal the destination bits 31:0.
- R5: For the low variant (code 2), start and end are taken modulo 32, index 0 is result bit 31, insertion happens only in bits 31:0, and result bits 63:32 equal the destination bits 63:32.
- R6: Bit 7 of `in_end` is the zero option. With it set in the full variant, every result bit outside the inserted run is 0.
- R7: With the zero option set in a half variant, bits of the active half outside the run are 0, and the other half still equals the destination.
- R8: With the zero option clear, every result bit outside the inserted run equals the destination bit.
- R9: Variant code 3 behaves exactly as the full variant.
- R10: `out_valid` equals `in_valid` from one clock earlier, and `out_result` carries that operation's result. A synchronous active-high reset clears `out_valid` and `out_result`.
- R11: While `in_valid` is low, `out_result` holds its last value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_variant | input | 2 | 0 full, 1 high half, 2 low half, 3 full |
| in_src | input | 64 | Operand that is rotated and inserted |
| in_dst | input | 64 | Operand that receives the inserted bits |
| in_start | input | 8 | Start index of the run (low bits used) |
| in_end | input | 8 | End index of the run (low bits), bit 7 zero option |
| in_rot | input | 8 | Left rotate amount (bits 5:0 used) |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| out_result | output | 64 | Registered merged result |

## Verification
A fault in the mask builder or the rotator has nothing to hide behind. It reaches `out_result` on the very next clock after the operation that exposes it. It shows as one or more bits taken from the wrong operand, or a bit cleared that should hold a value. Sweeping every start and end pair for every variant, with random operands, makes any bad mask entry show within one cycle of the pair that triggers it. A wrong valid or hold register shows as a mismatch on the idle cycles between bursts.

// File: rtl/rib_pkg.sv
package rib_pkg;

   typedef enum logic [1:0] {
      RIB_FULL = 2'd0,
      RIB_HIGH = 2'd1,
      RIB_LOW  = 2'd2,
      RIB_ALT  = 2'd3
   } rib_variant_e;

   function automatic logic rib_is_half(input logic [1:0] code);
      return (code == RIB_HIGH) || (code == RIB_LOW);
   endfunction

endpackage

// File: rtl/rib_rotl.sv
module rib_rotl #(
   parameter int W      = 64,
   parameter int SH_W   = $clog2(W),
   parameter bit STAGED = 1'b1
) (
   input  logic [W-1:0]    din,
   input  logic [SH_W-1:0] amt,
   output logic [W-1:0]    dout
);

   if ((1 << SH_W) != W) begin : g_bad_width
      $error("rib_rotl: W must equal 2**SH_W");
   end

   if (STAGED) begin : g_barrel
      logic [W-1:0] stage [SH_W+1];
      assign stage[0] = din;
      for (genvar k = 0; k < SH_W; k++) begin : g_stage
         localparam int SH = 1 << k;
         assign stage[k+1] = amt[k] ? {stage[k][W-1-SH:0], stage[k][W-1:W-SH]}
                                    : stage[k];
      end
      assign dout = stage[SH_W];
   end else begin : g_wide
      logic [2*W-1:0] dbl;
      assign dbl  = {din, din} << amt;
      assign dout = dbl[2*W-1:W];
   end

endmodule

// File: rtl/rib_mask_gen.sv
module rib_mask_gen
   import rib_pkg::*;
#(
   parameter int W     = 64,
   parameter int IDX_W = $clog2(W)
) (
   input  logic [1:0]       variant,
   input  logic [IDX_W-1:0] start_idx,
   input  logic [IDX_W-1:0] end_idx,
   input  logic             zero_opt,
   output logic [W-1:0]     ins_mask,
   output logic [W-1:0]     keep_mask
);

   localparam int HALF = W / 2;
   localparam logic [IDX_W-1:0] HALF_LIM = IDX_W'(HALF - 1);

   if (W < 4 || (W % 2) != 0 || (1 << IDX_W) != W) begin : g_bad_width
      $error("rib_mask_gen: W must be an even power of two of at least 4");
   end

   logic             is_half;
   logic             is_low;
   logic             is_high;
   logic [IDX_W-1:0] s_eff;
   logic [IDX_W-1:0] e_eff;
   logic             no_wrap;

   always_comb begin
      is_half = rib_is_half(variant);
      is_low  = (variant == RIB_LOW);
      is_high = (variant == RIB_HIGH);
      s_eff   = is_half ? (start_idx & HALF_LIM) : start_idx;
      e_eff   = is_half ? (end_idx & HALF_LIM) : end_idx;
      no_wrap = (s_eff <= e_eff);
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      localparam int UPPER_I = W - 1 - b;
      localparam int LOWER_I = (b < HALF) ? (HALF - 1 - b) : 0;
      localparam bit IN_UP   = (b >= HALF);

      logic [IDX_W-1:0] idx;
      logic             in_region;
      logic             hit;

      always_comb begin
         idx       = is_low ? IDX_W'(LOWER_I) : IDX_W'(UPPER_I);
         in_region = is_low ? !IN_UP : (is_high ? IN_UP : 1'b1);
         if (no_wrap) begin
            hit = (idx >= s_eff) && (idx <= e_eff);
         end else begin
            hit = (idx >= s_eff) || (idx <= e_eff);
         end
         ins_mask[b]  = in_region && hit;
         keep_mask[b] = !in_region || (!zero_opt && !hit);
      end
   end

endmodule

// File: rtl/rib_merge.sv
module rib_merge #(
   parameter int W = 64
) (
   input  logic [W-1:0] rot_src,
   input  logic [W-1:0] dst,
   input  logic [W-1:0] ins_mask,
   input  logic [W-1:0] keep_mask,
   output logic [W-1:0] merged
);

   always_comb begin
      merged = (rot_src & ins_mask) | (dst & keep_mask);
   end

endmodule

// File: rtl/rib_unit.sv
module rib_unit
   import rib_pkg::*;
#(
   parameter int W          = 64,
   parameter int IMM_W      = 8,
   parameter bit BARREL_ROT = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [1:0]       in_variant,
   input  logic [W-1:0]     in_src,
   input  logic [W-1:0]     in_dst,
   input  logic [IMM_W-1:0] in_start,
   input  logic [IMM_W-1:0] in_end,
   input  logic [IMM_W-1:0] in_rot,
   output logic             out_valid,
   output logic [W-1:0]     out_result
);

   localparam int IDX_W = $clog2(W);
   localparam int HALF  = W / 2;

   if (IMM_W <= IDX_W) begin : g_bad_imm
      $error("rib_unit: IMM_W must leave room for the zero option bit");
   end

   logic [W-1:0] rot_val;
   logic [W-1:0] ins_mask;
   logic [W-1:0] keep_mask;
   logic [W-1:0] merged;
   logic         zero_opt;

   assign zero_opt = in_end[IMM_W-1];

   rib_rotl #(
      .W      (W),
      .SH_W   (IDX_W),
      .STAGED (BARREL_ROT)
   ) u_rotl (
      .din  (in_src),
      .amt  (in_rot[IDX_W-1:0]),
      .dout (rot_val)
   );

   rib_mask_gen #(
      .W     (W),
      .IDX_W (IDX_W)
   ) u_mask (
      .variant   (in_variant),
      .start_idx (in_start[IDX_W-1:0]),
      .end_idx   (in_end[IDX_W-1:0]),
      .zero_opt  (zero_opt),
      .ins_mask  (ins_mask),
      .keep_mask (keep_mask)
   );

   rib_merge #(
      .W (W)
   ) u_merge (
      .rot_src   (rot_val),
      .dst       (in_dst),
      .ins_mask  (ins_mask),
      .keep_mask (keep_mask),
      .merged    (merged)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         out_result <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result <= merged;
         end
      end
   end

   // R8
   mask_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> ((ins_mask & keep_mask) == '0));

   // R3
   mask_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> (ins_mask != '0));

   // R4
   high_confine_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_variant == RIB_HIGH) |-> (ins_mask[HALF-1:0] == '0));

   // R5
   low_confine_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_variant == RIB_LOW) |-> (ins_mask[W-1:HALF] == '0));

   // R7
   high_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_variant == RIB_HIGH)
      |=> (out_result[HALF-1:0] == $past(in_dst[HALF-1:0])));

   // R7
   low_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_variant == RIB_LOW)
      |=> (out_result[W-1:HALF] == $past(in_dst[W-1:HALF])));

   // R6
   zero_full_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && zero_opt && !rib_is_half(in_variant))
      |=> ((out_result & ~$past(ins_mask)) == '0));

   // R10
   valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   // R10
   valid_fall_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_result));

endmodule

// File: tb/rib_unit_bench.sv
module rib_unit_bench;

   localparam int CLK_PERIOD = 10;
   localparam int MAX_CYCLES = 100000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [1:0]  in_variant = 2'd0;
   logic [63:0] in_src = '0;
   logic [63:0] in_dst = '0;
   logic [7:0]  in_start = '0;
   logic [7:0]  in_end = '0;
   logic [7:0]  in_rot = '0;
   logic        out_valid;
   logic [63:0] out_result;

   int    total = 0;
   int    bad = 0;
   bit    done = 0;
   string cur_tag = "R10";

   bit          exp_v_q[$];
   logic [63:0] exp_r_q[$];
   string       exp_t_q[$];
   logic [63:0] hold_r = '0;

   rib_unit u_rib_unit (
      .clk        (clk),
      .rst        (rst),
      .in_valid   (in_valid),
      .in_variant (in_variant),
      .in_src     (in_src),
      .in_dst     (in_dst),
      .in_start   (in_start),
      .in_end     (in_end),
      .in_rot     (in_rot),
      .out_valid  (out_valid),
      .out_result (out_result)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [63:0] model(input logic [1:0] v, input logic [63:0] src,
                                         input logic [63:0] dst, input logic [7:0] s,
                                         input logic [7:0] e, input logic [7:0] r);
      int w, sm, em, amt, bitpos;
      bit z, take;
      logic [63:0] rs, res;
      w   = (v == 2'd1 || v == 2'd2) ? 32 : 64;
      sm  = int'(s) % w;
      em  = int'(e[6:0]) % w;
      z   = e[7];
      amt = int'(r) % 64;
      rs  = (amt == 0) ? src : ((src << amt) | (src >> (64 - amt)));
      res = dst;
      for (int k = 0; k < w; k++) begin
         take   = (sm <= em) ? (k >= sm && k <= em) : (k >= sm || k <= em);
         bitpos = (v == 2'd2) ? (31 - k) : (63 - k);
         if (take) res[bitpos] = rs[bitpos];
         else if (z) res[bitpos] = 1'b0;
      end
      return res;
   endfunction

   function automatic string tag_of(input logic [1:0] v, input logic [7:0] s, input logic [7:0] e);
      if (v == 2'd3) return "R9";
      if (v == 2'd1) return e[7] ? "R7" : "R4";
      if (v == 2'd2) return e[7] ? "R7" : "R5";
      if (e[7]) return "R6";
      return ((s % 64) > (e % 64)) ? "R3" : "R2";
   endfunction

   // monitor: compares outputs against the expectation queued one cycle earlier
   always @(negedge clk) begin
      bit          ev;
      logic [63:0] er;
      string       et;
      if (!done) begin
         if (exp_v_q.size() > 0) begin
            ev = exp_v_q.pop_front();
            er = exp_r_q.pop_front();
            et = exp_t_q.pop_front();
            total++;
            if (out_valid !== ev) begin
               bad++;
               $display("FAIL R10 out_valid actual=%0b expected=%0b", out_valid, ev);
            end
            total++;
            if (out_result !== er) begin
               bad++;
               $display("FAIL %s out_result actual=%h expected=%h", et, out_result, er);
            end
         end
         if (rst) begin
            hold_r = '0;
            exp_v_q.push_back(1'b0);
            exp_r_q.push_back('0);
            exp_t_q.push_back("R10");
         end else if (in_valid) begin
            hold_r = model(in_variant, in_src, in_dst, in_start, in_end, in_rot);
            exp_v_q.push_back(1'b1);
            exp_r_q.push_back(hold_r);
            exp_t_q.push_back(cur_tag);
         end else begin
            exp_v_q.push_back(1'b0);
            exp_r_q.push_back(hold_r);
            exp_t_q.push_back("R11");
         end
      end
   end

   task automatic drive(input logic [1:0] v, input logic [63:0] src, input logic [63:0] dst,
                        input logic [7:0] s, input logic [7:0] e, input logic [7:0] r,
                        input string tag);
      @(posedge clk);
      #1;
      in_valid   = 1'b1;
      in_variant = v;
      in_src     = src;
      in_dst     = dst;
      in_start   = s;
      in_end     = e;
      in_rot     = r;
      cur_tag    = tag;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
         in_valid   = 1'b0;
         in_variant = 2'($urandom);
         in_src     = {$urandom, $urandom};
         in_dst     = {$urandom, $urandom};
         in_start   = 8'($urandom);
         in_end     = 8'($urandom);
         in_rot     = 8'($urandom);
         cur_tag    = "R11";
      end
   endtask

   task automatic finish_run();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      // R10: reset state observed while reset is held
      repeat (3) @(posedge clk);
      #1;
      rst = 1'b0;
      idle(2);

      // R1: full-width window exposes the raw rotation, including amounts of 64 and above
      for (int r = 0; r < 256; r += 7) begin
         drive(2'd0, 64'h0123_4567_89ab_cdef, {$urandom, $urandom}, 8'd0, 8'd63, 8'(r), "R1");
      end
      drive(2'd0, 64'h8000_0000_0000_0001, '0, 8'd0, 8'd63, 8'd65, "R1");
      idle(1);

      // R8: zero option clear keeps every destination bit outside the run
      drive(2'd0, '0, 64'hffff_ffff_ffff_ffff, 8'd10, 8'd20, 8'd0, "R8");
      drive(2'd1, '0, 64'hffff_ffff_ffff_ffff, 8'd3, 8'd1, 8'd5, "R8");
      drive(2'd2, 64'hffff_ffff_ffff_ffff, '0, 8'd31, 8'd0, 8'd0, "R8");

      // R6 / R3 corners: single bit at each end, full wrap
      drive(2'd0, 64'hffff_ffff_ffff_ffff, 64'h5555_5555_5555_5555, 8'd63, 8'h80, 8'd0, "R6");
      drive(2'd0, 64'hffff_ffff_ffff_ffff, 64'h5555_5555_5555_5555, 8'd40, 8'd39, 8'd3, "R3");
      idle(3);

      // R2 R3 R4 R5 R6 R7 R9: every start/end pair for every variant code
      for (int v = 0; v < 4; v++) begin
         for (int s = 0; s < 64; s++) begin
            for (int e = 0; e < 64; e++) begin
               logic [7:0] si, ei;
               si = {2'($urandom), 6'(s)};
               ei = {1'($urandom), 1'($urandom), 6'(e)};
               drive(2'(v), {$urandom, $urandom}, {$urandom, $urandom}, si, ei,
                     8'($urandom), tag_of(2'(v), si, ei));
               if ((e % 29) == 0) idle(1);
            end
         end
      end

      // R11: long idle stretch with toggling inputs
      idle(20);
      finish_run();
   end

   initial begin
      repeat (MAX_CYCLES) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         finish_run();
      end
   end

endmodule